// File: doc/BRIEF.md
# Configuration Register Serial Slave

This block is a two-wire serial slave that gives an external bus controller read and write access to a small bank of configuration bytes. The bytes could, for instance, hold per-output enable bits of a clock generator. Both wires are sampled into the system clock domain through a synchronizer. The slave answers one fixed 7-bit address (69h, seen on the wire as D2h for writes and D3h for reads). It pulls the data line low for acknowledges and for zero bits of read data, and otherwise leaves it released.

After the address, a command byte selects the access type. With bit 7 set, one register is addressed by the offset in bits 4:0. With bit 7 clear, the access is a counted block that always starts at register 0 and walks upward. Bits 6:5 must be zero for the device to take the command. A read is a write of address and command, then a repeated start, then the address with the read bit. A block write carries a count byte ahead of its data unless a skip bit in the bank is set. A block read returns a count byte first.

States of the protocol machine: ST_IDLE (bus free), ST_ADDR (shifting address), ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_COUNT (block-write count), ST_COUNT_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA (slave drives a byte), ST_RDATA_ACK (controller acknowledges), and ST_WAIT (ignore traffic until the next start). The transitions are as follows. A stop from any state goes to ST_IDLE, and a start or repeated start from any state goes to ST_ADDR. ST_ADDR moves to ST_ADDR_ACK on an address hit and to ST_WAIT otherwise. ST_ADDR_ACK moves to ST_RDATA for a read and to ST_CMD for a write. ST_CMD moves to ST_CMD_ACK when bits 6:5 are zero and to ST_WAIT otherwise. ST_CMD_ACK moves to ST_WDATA for single-byte mode or when the skip bit is set, and to ST_COUNT otherwise. ST_COUNT_ACK moves to ST_WDATA, and so does ST_WDATA_ACK. ST_RDATA moves to ST_RDATA_ACK after eight bits. ST_RDATA_ACK moves to ST_RDATA if the controller acknowledged and to ST_WAIT on a NACK.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, registers 0 to 6 hold FFh, register 7 holds 00h, and the slave does not pull the data line.
- R2: Only the address byte D2h (write) or D3h (read) is acknowledged. Any other address gets a NACK, and the following bytes until the next start get a NACK and change no register.
- R3: A command byte with bits 6:5 not 00 gets a NACK. It and the bytes that follow it until the next start change no register.
- R4: A command with bit 7 = 1 selects single-byte access at the offset in bits 4:0. A data byte written after it lands in that register and is acknowledged.
- R5: Address plus single-byte command, then a repeated start and D3h, returns the addressed register most significant bit first.
- R6: A command with bit 7 = 0 selects block write. One count byte (acknowledged, value unused) comes first. Data bytes then fill registers from 0 upward, whatever the count says.
- R7: A stop after any complete data byte ends a block write, and the bytes already written keep their values.
- R8: A block read returns a count byte equal to the bank size (08h) and then registers 0, 1, 2 and so on in order.
- R9: Offsets 8 and above are acknowledged on write but change nothing, and they read back as 00h.
- R10: While bit 0 of register 7 is 1, a block write carries no count byte, so the first data byte goes to register 0.
- R11: After the controller NACKs a read byte, the slave leaves the data line released until the next start.
- R12: The slave changes its pull on the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| reg_image | output | 64 | All register contents, register k in bits 8k+7:8k |

## Verification
On every cycle the checker shows four things. The data-line pull moves only while the synchronized clock is low. The pull is asserted only in acknowledge and read-data states, and never in ST_IDLE or ST_WAIT. The register image changes only right after a completed write-data byte. Which byte lands where, the count byte values, the rejection of wrong addresses and device-select bits, the skipped count phase, and the out-of-range reads are shown only by the bench's transactions, which compare acknowledge bits, returned bytes and the register image against a model.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_WAIT
    } link_state_t;

    // width of the register offset field in the command byte
    localparam int OFS_W = 5;

endpackage

// File: rtl/cfg_serial_sync.sv
module cfg_serial_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // idle bus is high, so the pipes reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
    import cfg_serial_pkg::*;
#(
    parameter int                   NREGS       = 8,
    parameter logic [NREGS*8-1:0]   RESET_IMAGE = {8'h00, {7{8'hFF}}},
    parameter int                   SKIP_REG    = 7,
    parameter int                   SKIP_BIT    = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFS_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [OFS_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    output logic               skip_count,
    output logic [NREGS*8-1:0] reg_image
);

    logic [7:0] bank_q [NREGS];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_q[g] <= RESET_IMAGE[g*8 +: 8];
                end else if (wr_en && (int'(wr_idx) == g)) begin
                    bank_q[g] <= wr_data;
                end
            end
            assign reg_image[g*8 +: 8] = bank_q[g];
        end
    endgenerate

    // offsets past the bank read as zero
    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NREGS; k++) begin
            if (int'(rd_idx) == k) rd_data = bank_q[k];
        end
    end

    assign skip_count = bank_q[SKIP_REG][SKIP_BIT];

endmodule

// File: rtl/cfg_serial_fsm.sv
module cfg_serial_fsm
    import cfg_serial_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREGS    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             skip_count,
    input  logic [7:0]       rd_data,
    output logic [OFS_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [OFS_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_pull,
    output link_state_t      state
);

    localparam logic [7:0]       COUNT_BYTE = 8'(NREGS);
    localparam logic [OFS_W-1:0] OFS_LAST   = '1;

    link_state_t      state_q, state_d;
    logic [2:0]       bit_q;
    logic             done_q;
    logic [7:0]       rx_q;
    logic [7:0]       tx_q;
    logic             is_rd_q;
    logic             blk_q;
    logic             got_ack_q;
    logic [OFS_W-1:0] ptr_q;

    logic byte_end, rx_phase, addr_hit, cmd_ok, wr_fire;
    logic [OFS_W-1:0] ptr_next;

    assign byte_end = scl_fall & done_q;
    assign rx_phase = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                      (state_q == ST_COUNT) || (state_q == ST_WDATA);
    assign addr_hit = (rx_q[7:1] == DEV_ADDR);
    assign cmd_ok   = (rx_q[6:5] == 2'b00);
    assign ptr_next = (ptr_q == OFS_LAST) ? ptr_q : ptr_q + 1'b1;
    assign wr_fire  = (state_q == ST_WDATA) && byte_end && !start_det && !stop_det;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT:      state_d = ST_WAIT;
                ST_ADDR:      if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall) state_d = is_rd_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_end) state_d = cmd_ok ? ST_CMD_ACK : ST_WAIT;
                ST_CMD_ACK:   if (scl_fall) state_d = (!blk_q || skip_count) ? ST_WDATA : ST_COUNT;
                ST_COUNT:     if (byte_end) state_d = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (byte_end) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_d = got_ack_q ? ST_RDATA : ST_WAIT;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q     <= '0;
            done_q    <= 1'b0;
            rx_q      <= '0;
            tx_q      <= '1;
            is_rd_q   <= 1'b0;
            blk_q     <= 1'b0;
            got_ack_q <= 1'b0;
            ptr_q     <= '0;
        end else begin
            if ((state_d != state_q) || start_det) begin
                bit_q  <= '0;
                done_q <= 1'b0;
            end else if (scl_rise && (rx_phase || (state_q == ST_RDATA))) begin
                bit_q  <= bit_q + 1'b1;
                done_q <= (bit_q == 3'd7);
            end
            if (scl_rise && rx_phase) rx_q <= {rx_q[6:0], sda_s};
            if ((state_q == ST_RDATA) && scl_fall && !done_q) tx_q <= {tx_q[6:0], 1'b0};
            if ((state_q == ST_RDATA_ACK) && scl_rise) got_ack_q <= !sda_s;
            if ((state_q == ST_ADDR) && (state_d == ST_ADDR_ACK)) is_rd_q <= rx_q[0];
            if ((state_q == ST_CMD) && (state_d == ST_CMD_ACK)) begin
                blk_q <= !rx_q[7];
                ptr_q <= rx_q[7] ? rx_q[OFS_W-1:0] : '0;
            end
            if (wr_fire) ptr_q <= ptr_next;
            if ((state_d == ST_RDATA) && (state_q != ST_RDATA)) begin
                if ((state_q == ST_ADDR_ACK) && blk_q) begin
                    tx_q <= COUNT_BYTE;
                end else begin
                    tx_q  <= rd_data;
                    ptr_q <= ptr_next;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA:                                            sda_pull = !tx_q[7];
            default:                                             sda_pull = 1'b0;
        endcase
    end

    assign rd_idx  = ptr_q;
    assign wr_en   = wr_fire;
    assign wr_idx  = ptr_q;
    assign wr_data = rx_q;
    assign state   = state_q;

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_serial_pkg::*;
#(
    parameter logic [6:0]         DEV_ADDR    = 7'h69,
    parameter int                 NREGS       = 8,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [NREGS*8-1:0] RESET_IMAGE = {8'h00, {7{8'hFF}}},
    parameter int                 SKIP_REG    = 7,
    parameter int                 SKIP_BIT    = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    output logic [NREGS*8-1:0] reg_image
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             skip_count, wr_en;
    logic [7:0]       rd_data, wr_data;
    logic [OFS_W-1:0] rd_idx, wr_idx;
    link_state_t      link_state;

    cfg_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_serial_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .skip_count (skip_count),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .sda_pull   (sda_pull),
        .state      (link_state)
    );

    cfg_serial_regs #(
        .NREGS       (NREGS),
        .RESET_IMAGE (RESET_IMAGE),
        .SKIP_REG    (SKIP_REG),
        .SKIP_BIT    (SKIP_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .skip_count (skip_count),
        .reg_image  (reg_image)
    );

endmodule

// File: rtl/cfg_serial_chk.sv
module cfg_serial_chk
    import cfg_serial_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_pull,
    input  link_state_t        state,
    input  logic [NREGS*8-1:0] reg_image
);

    // R12: the pull only moves while the synchronized clock is low
    assert_pull_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);

    // R1: no pull on an idle bus
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    // R11 and R2: ignored traffic and post-NACK periods leave the line alone
    assert_wait_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull);

    // R11: pull only in acknowledge or read-data states
    assert_pull_states_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state inside {ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK,
                                    ST_WDATA_ACK, ST_RDATA}));

    // R4 and R6: the bank changes only right after a completed data byte
    assert_bank_write_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_image) |-> ($past(state) == ST_WDATA) && (state == ST_WDATA_ACK));

endmodule

bind cfg_serial_slave cfg_serial_chk #(.NREGS(NREGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_pull  (sda_pull),
    .state     (link_state),
    .reg_image (reg_image)
);

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;

    localparam int Q = 10;   // clock cycles per bus quarter step

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [63:0] reg_image;
    wire         sda_line = sda_m & ~sda_pull;

    int    checks = 0;
    int    fails = 0;
    int    glitches = 0;
    bit    finished = 0;
    logic  prev_pull = 1'b0;
    logic [7:0] model [8];
    item_t exp_q [$];
    logic [7:0] obs_q [$];
    item_t cur_e;
    logic [7:0] cur_o;

    always #2 clk = ~clk;   // 250 MHz

    cfg_serial_slave i_cfg_serial_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .reg_image (reg_image)
    );

    // scoreboard monitor: pairs expected items with observed bus values
    always @(negedge clk) begin
        if (exp_q.size() > 0 && obs_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            cur_o = obs_q.pop_front();
            checks++;
            if (cur_o !== cur_e.v) begin
                fails++;
                $display("FAIL %s: actual %02h expected %02h", cur_e.tag, cur_o, cur_e.v);
            end
        end
    end

    // R12 observer: slave pull must not move while the controller holds SCL high
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_pull !== prev_pull)) glitches++;
        prev_pull <= sda_pull;
    end

    task automatic tick();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic check_bank(input string tag);
        logic [63:0] m;
        for (int k = 0; k < 8; k++) m[k*8 +: 8] = model[k];
        check(tag, reg_image, m);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick();
        sda_m = 1'b0; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b0; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b1; tick();
    endtask

    // driver: sends a byte and queues the expected acknowledge level (0 = ACK)
    task automatic send_byte(input logic [7:0] b, input bit want_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick();
            scl_m = 1'b1; tick();
            scl_m = 1'b0; tick();
        end
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        exp_q.push_back('{v: want_ack ? 8'h00 : 8'h01, tag: tag});
        obs_q.push_back({7'b0, sda_line});
        scl_m = 1'b0; tick();
    endtask

    // driver: receives a byte, queues expected and observed, then acks or nacks
    task automatic recv_byte(input bit give_ack, input logic [7:0] e, input string tag);
        logic [7:0] v;
        sda_m = 1'b1;
        exp_q.push_back('{v: e, tag: tag});
        for (int i = 7; i >= 0; i--) begin
            tick();
            scl_m = 1'b1; tick();
            v[i] = sda_line;
            scl_m = 1'b0;
        end
        obs_q.push_back(v);
        tick();
        sda_m = give_ack ? 1'b0 : 1'b1; tick();
        scl_m = 1'b1; tick();
        scl_m = 1'b0; tick();
        sda_m = 1'b1;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int k = 0; k < 7; k++) model[k] = 8'hFF;
        model[7] = 8'h00;
        repeat (5) @(negedge clk);
        // R1: reset defaults and released line
        check_bank("R1 reset image");
        check("R1 reset pull", {63'b0, sda_pull}, 64'd0);
        rst_n = 1'b1;
        tick();

        // R4: single-byte write to register 3
        bus_start();
        send_byte(8'hD2, 1, "R2 write address ack");
        send_byte(8'h83, 1, "R4 byte command ack");
        send_byte(8'h5A, 1, "R4 data ack");
        bus_stop();
        model[3] = 8'h5A;
        check_bank("R4 byte write");

        // R5: single-byte read of register 3
        bus_start();
        send_byte(8'hD2, 1, "R5 address ack");
        send_byte(8'h83, 1, "R5 command ack");
        bus_rstart();
        send_byte(8'hD3, 1, "R2 read address ack");
        recv_byte(0, 8'h5A, "R5 read data");
        check("R11 released after nack", {63'b0, sda_pull}, 64'd0);
        bus_stop();

        // R6 and R7: block write, count 5 but stop after three bytes
        bus_start();
        send_byte(8'hD2, 1, "R6 address ack");
        send_byte(8'h00, 1, "R6 block command ack");
        send_byte(8'h05, 1, "R6 count ack");
        send_byte(8'h11, 1, "R6 data0 ack");
        send_byte(8'h22, 1, "R6 data1 ack");
        send_byte(8'h33, 1, "R6 data2 ack");
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        check_bank("R7 early stop keeps bytes");

        // R6: count 1 does not limit the data accepted
        bus_start();
        send_byte(8'hD2, 1, "R6 address ack");
        send_byte(8'h00, 1, "R6 block command ack");
        send_byte(8'h01, 1, "R6 count ack");
        send_byte(8'h44, 1, "R6 data0 ack");
        send_byte(8'h55, 1, "R6 data1 beyond count ack");
        bus_stop();
        model[0] = 8'h44; model[1] = 8'h55;
        check_bank("R6 count not limiting");

        // R8: block read
        bus_start();
        send_byte(8'hD2, 1, "R8 address ack");
        send_byte(8'h00, 1, "R8 block command ack");
        bus_rstart();
        send_byte(8'hD3, 1, "R8 read address ack");
        recv_byte(1, 8'h08, "R8 count byte");
        for (int k = 0; k < 8; k++) recv_byte(k != 7, model[k], "R8 block data");
        check("R11 released after block nack", {63'b0, sda_pull}, 64'd0);
        bus_stop();

        // R2: foreign address ignored until next start
        bus_start();
        send_byte(8'hD4, 0, "R2 foreign address nack");
        send_byte(8'h83, 0, "R2 ignored command nack");
        send_byte(8'h77, 0, "R2 ignored data nack");
        bus_stop();
        check_bank("R2 bank unchanged");

        // R3: nonzero device-select bits
        bus_start();
        send_byte(8'hD2, 1, "R3 address ack");
        send_byte(8'hA3, 0, "R3 bad select nack");
        send_byte(8'h66, 0, "R3 following byte nack");
        bus_stop();
        check_bank("R3 bank unchanged");

        // R9: out-of-range write and read
        bus_start();
        send_byte(8'hD2, 1, "R9 address ack");
        send_byte(8'h8A, 1, "R9 command ack");
        send_byte(8'hEE, 1, "R9 data ack");
        bus_stop();
        check_bank("R9 write ignored");
        bus_start();
        send_byte(8'hD2, 1, "R9 address ack");
        send_byte(8'h9F, 1, "R9 command ack");
        bus_rstart();
        send_byte(8'hD3, 1, "R9 read address ack");
        recv_byte(0, 8'h00, "R9 read zero");
        bus_stop();

        // R10: set skip bit then block write without count
        bus_start();
        send_byte(8'hD2, 1, "R10 address ack");
        send_byte(8'h87, 1, "R10 command ack");
        send_byte(8'h01, 1, "R10 skip set ack");
        bus_stop();
        model[7] = 8'h01;
        bus_start();
        send_byte(8'hD2, 1, "R10 address ack");
        send_byte(8'h00, 1, "R10 block command ack");
        send_byte(8'hA1, 1, "R10 data0 ack");
        send_byte(8'hA2, 1, "R10 data1 ack");
        bus_stop();
        model[0] = 8'hA1; model[1] = 8'hA2;
        check_bank("R10 no count byte");

        // R9: nine-byte block write, ninth ignored
        bus_start();
        send_byte(8'hD2, 1, "R9 address ack");
        send_byte(8'h00, 1, "R9 block command ack");
        for (int k = 0; k < 7; k++) begin
            send_byte(8'hB0 + 8'(k), 1, "R9 block data ack");
            model[k] = 8'hB0 + 8'(k);
        end
        send_byte(8'h01, 1, "R9 block data7 ack");
        send_byte(8'hC9, 1, "R9 past-bank ack");
        bus_stop();
        check_bank("R9 past-bank ignored");

        tick();
        check("R12 pull stable while clock high", 64'(glitches), 64'd0);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size() + obs_q.size());
        end
        report();
    end

endmodule